// File: doc/BRIEF.md
# DAC Power-Up and Control-Source Sequencer

This block decides how a multichannel audio converter is brought out of reset and what configures it. When reset is released, the block sits in a low-power wait and counts periods of the audio frame clock. The frame clock is asynchronous to the system clock and is synchronised before its rising edges are counted. The length of the wait depends on the speed-mode input. Two events race during the wait. If a control-port enable write arrives first, the block hands control to its registers. If the wait runs out first, the block takes a snapshot of four strap pins and starts a power-up sequence on its own.

In register control, a power-down bit keeps the converter parked. Clearing that bit starts a timed power-up of `PWRUP_CYCLES` system clocks. At the end of it the filter-ready output rises. An enable write is honoured even after the strap-pin sequence has begun, and it then takes over from the pins. Mute, ramp enables and the active mode word are brought out as status outputs, so the surrounding data path can act on them.

Top module: `dac_pwr_seq`

## Requirements
- R1: While reset is asserted and right after it is released, the outputs are as follows. `ctrl_src` is 0 (undecided), `pwr_state` is 0 (wait), `filt_ready` is 0, `mute_out` is all ones, both ramp enables are 0 and `active_mode` is 0.
- R2: The wait lasts 512 frame-clock rising edges when `speed_sel` is 00, 1024 when it is 01 and 2048 when it is 10. The value 11 behaves as 00. One edge short of the count, `ctrl_src` is still 0.
- R3: A write with `wr_sel`=0 and `wr_data[0]`=1 (enable bit) before the wait ends sets `ctrl_src` to 2 (registers). No strap-pin sequence follows, no matter how many frame edges arrive later.
- R4: If the wait ends with no enable write, `ctrl_src` becomes 1 (pins) and `active_mode` takes the value of `mode_pins`. A power-up sequence then starts (`pwr_state` 2).
- R5: An enable write made while `ctrl_src` is 1 switches `ctrl_src` to 2 and restarts power-up under register control. `ctrl_src` stays at 2 until reset.
- R6: Under register control, `wr_data[1]`=1 (power-down bit) in the same control write holds `pwr_state` at 1 (parked) with `filt_ready` low. With that bit at 0, `pwr_state` is 2 for `PWRUP_CYCLES` clocks. After that it is 3 (running) and `filt_ready` is 1.
- R7: `mute_out` is all ones unless `pwr_state` is 3. While running, it equals the mute register (`wr_sel`=1, one bit per channel) under register control, and all zeros under pin control.
- R8: In a control write, `ramp_up_en` follows `wr_data[2]` and `ramp_dn_en` follows `wr_data[3]`. Both outputs are 0 whenever `ctrl_src` is not 2.
- R9: Under pin control, later changes on `mode_pins` do not alter `active_mode`. Under register control, `active_mode` shows the mode register (`wr_sel`=2, bits 3:0).
- R10: Under register control, setting the power-down bit to 1 again sends a running converter back to `pwr_state` 1. This drops `filt_ready` and sets `mute_out` to all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| frame_clk | input | 1 | Asynchronous audio frame clock |
| speed_sel | input | 2 | Speed mode: 00 single, 01 double, 10 quad, 11 as single |
| mode_pins | input | 4 | Strap-pin mode word |
| wr_en | input | 1 | Register write strobe, one cycle |
| wr_sel | input | 2 | Register select: 0 control, 1 mute, 2 mode |
| wr_data | input | NCH | Write data |
| ctrl_src | output | 2 | 0 undecided, 1 pins, 2 registers |
| pwr_state | output | 2 | 0 wait, 1 parked, 2 powering up, 3 running |
| filt_ready | output | 1 | High once power-up has completed |
| ramp_up_en | output | 1 | Ramp-up enable |
| ramp_dn_en | output | 1 | Ramp-down enable |
| mute_out | output | NCH | Per-channel mute |
| active_mode | output | 4 | Mode word in force |

## Verification
The assertions assume the following about the inputs:
- `speed_sel` holds steady for the whole wait.
- Each write strobe lasts a single cycle.
- Each phase of the frame clock spans more system clocks than the synchroniser depth plus one, so that no frame edge is merged or lost.

The bench meets all three. It changes `speed_sel` and `mode_pins` only while reset is held. It issues every write as a one-cycle pulse. It drives the frame clock with four-cycle high and low phases. Under those limits, the edge count seen by the design matches the count of edges the bench generates.

// File: rtl/dac_seq_pkg.sv
package dac_seq_pkg;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_PIN  = 2'd1,
    SRC_REG  = 2'd2
  } src_e;

  typedef enum logic [1:0] {
    PS_WAIT  = 2'd0,
    PS_HOLD  = 2'd1,
    PS_PWRUP = 2'd2,
    PS_RUN   = 2'd3
  } pstate_e;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_MUTE = 2'd1;
  localparam logic [1:0] SEL_MODE = 2'd2;

  localparam int BIT_CPEN  = 0;
  localparam int BIT_PDN   = 1;
  localparam int BIT_RUP   = 2;
  localparam int BIT_RDN   = 3;
  localparam int MODE_W    = 4;

  // Wait length in frame periods for a speed code; the reserved code acts as single speed.
  function automatic int unsigned frames_for_speed(input logic [1:0] spd,
                                                   input int unsigned base);
    case (spd)
      2'b01:   return base * 2;
      2'b10:   return base * 4;
      default: return base;
    endcase
  endfunction

endpackage

// File: rtl/dac_edge_sync.sv
module dac_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= async_in;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], async_in};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= sync_q[STAGES-1];
  end

  assign rise = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/dac_ctrl_regs.sv
module dac_ctrl_regs
  import dac_seq_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [NCH-1:0]    wr_data,
  output logic              cpen_write,
  output logic              pdn_eff,
  output logic              ramp_up_q,
  output logic              ramp_dn_q,
  output logic [NCH-1:0]    mute_q,
  output logic [MODE_W-1:0] mode_q
);
  logic ctrl_hit;
  logic pdn_q;

  assign ctrl_hit   = wr_en && (wr_sel == SEL_CTRL);
  assign cpen_write = ctrl_hit && wr_data[BIT_CPEN];
  // Power-down value as it stands after any write in this cycle.
  assign pdn_eff    = ctrl_hit ? wr_data[BIT_PDN] : pdn_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pdn_q     <= 1'b1;
      ramp_up_q <= 1'b0;
      ramp_dn_q <= 1'b0;
    end else if (ctrl_hit) begin
      pdn_q     <= wr_data[BIT_PDN];
      ramp_up_q <= wr_data[BIT_RUP];
      ramp_dn_q <= wr_data[BIT_RDN];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              mute_q <= '0;
    else if (wr_en && (wr_sel == SEL_MUTE))  mute_q <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              mode_q <= '0;
    else if (wr_en && (wr_sel == SEL_MODE))  mode_q <= wr_data[MODE_W-1:0];
  end
endmodule

// File: rtl/dac_frame_wait.sv
module dac_frame_wait #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic          tick,
  input  logic [CW-1:0] limit,
  output logic          expired
);
  logic [CW-1:0] cnt_q;

  assign expired = active && tick && (cnt_q == limit - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (!active)         cnt_q <= '0;
    else if (tick && !expired) cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/dac_pwr_timer.sv
module dac_pwr_timer #(
  parameter int CYCLES = 2500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic active,
  output logic done
);
  localparam int TW = $clog2(CYCLES + 1);
  logic [TW-1:0] cnt_q;

  assign done = active && !start && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt_q <= '0;
    else if (start)                 cnt_q <= TW'(CYCLES - 1);
    else if (active && cnt_q != '0) cnt_q <= cnt_q - TW'(1);
  end
endmodule

// File: rtl/dac_pwr_seq.sv
module dac_pwr_seq
  import dac_seq_pkg::*;
#(
  parameter int NCH          = 8,
  parameter int BASE_FRAMES  = 512,
  parameter int PWRUP_CYCLES = 2500,
  parameter int SYNC_STAGES  = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           frame_clk,
  input  logic [1:0]     speed_sel,
  input  logic [3:0]     mode_pins,
  input  logic           wr_en,
  input  logic [1:0]     wr_sel,
  input  logic [NCH-1:0] wr_data,
  output logic [1:0]     ctrl_src,
  output logic [1:0]     pwr_state,
  output logic           filt_ready,
  output logic           ramp_up_en,
  output logic           ramp_dn_en,
  output logic [NCH-1:0] mute_out,
  output logic [3:0]     active_mode
);
  localparam int WAIT_W = $clog2(BASE_FRAMES * 4 + 1);

  // Named internal events
  logic frame_tick;
  logic wait_expired;
  logic cpen_write;
  logic pdn_eff;
  logic pwr_start;
  logic pwr_done;

  logic              ramp_up_q, ramp_dn_q;
  logic [NCH-1:0]    mute_q;
  logic [MODE_W-1:0] mode_q;
  logic [MODE_W-1:0] pin_mode_q;
  logic              pin_latch;
  logic [WAIT_W-1:0] wait_limit;

  src_e    src_q, src_n;
  pstate_e st_q, st_n;

  dac_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(frame_clk), .rise(frame_tick)
  );

  dac_ctrl_regs #(.NCH(NCH)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .cpen_write(cpen_write), .pdn_eff(pdn_eff), .ramp_up_q(ramp_up_q),
    .ramp_dn_q(ramp_dn_q), .mute_q(mute_q), .mode_q(mode_q)
  );

  assign wait_limit = WAIT_W'(frames_for_speed(speed_sel, BASE_FRAMES));

  dac_frame_wait #(.CW(WAIT_W)) u_wait (
    .clk(clk), .rst_n(rst_n), .active(st_q == PS_WAIT && src_q == SRC_NONE),
    .tick(frame_tick), .limit(wait_limit), .expired(wait_expired)
  );

  dac_pwr_timer #(.CYCLES(PWRUP_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(pwr_start), .active(st_q == PS_PWRUP),
    .done(pwr_done)
  );

  always_comb begin
    src_n     = src_q;
    st_n      = st_q;
    pwr_start = 1'b0;
    pin_latch = 1'b0;
    if (src_q != SRC_REG && cpen_write) begin
      // Enable write wins over a simultaneous timeout and over pin control.
      src_n = SRC_REG;
      if (pdn_eff) begin
        st_n = PS_HOLD;
      end else begin
        st_n      = PS_PWRUP;
        pwr_start = 1'b1;
      end
    end else begin
      case (st_q)
        PS_WAIT: if (wait_expired) begin
          src_n     = SRC_PIN;
          st_n      = PS_PWRUP;
          pwr_start = 1'b1;
          pin_latch = 1'b1;
        end
        PS_HOLD: if (!pdn_eff) begin
          st_n      = PS_PWRUP;
          pwr_start = 1'b1;
        end
        PS_PWRUP: begin
          if (src_q == SRC_REG && pdn_eff) st_n = PS_HOLD;
          else if (pwr_done)              st_n = PS_RUN;
        end
        default: if (src_q == SRC_REG && pdn_eff) st_n = PS_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= SRC_NONE;
      st_q  <= PS_WAIT;
    end else begin
      src_q <= src_n;
      st_q  <= st_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pin_mode_q <= '0;
    else if (pin_latch) pin_mode_q <= mode_pins;
  end

  assign ctrl_src    = src_q;
  assign pwr_state   = st_q;
  assign filt_ready  = (st_q == PS_RUN);
  assign ramp_up_en  = (src_q == SRC_REG) && ramp_up_q;
  assign ramp_dn_en  = (src_q == SRC_REG) && ramp_dn_q;
  assign mute_out    = (st_q != PS_RUN) ? '1 : ((src_q == SRC_REG) ? mute_q : '0);
  assign active_mode = (src_q == SRC_PIN) ? pin_mode_q :
                       (src_q == SRC_REG) ? mode_q : '0;
endmodule

// File: rtl/dac_pwr_seq_chk.sv
module dac_pwr_seq_chk
  import dac_seq_pkg::*;
#(
  parameter int NCH = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic [1:0]     ctrl_src,
  input logic [1:0]     pwr_state,
  input logic           filt_ready,
  input logic           ramp_up_en,
  input logic           ramp_dn_en,
  input logic [NCH-1:0] mute_out,
  input logic [3:0]     active_mode,
  input logic           wait_expired,
  input logic           cpen_write
);
  assert_src_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_src == SRC_REG |=> ctrl_src == SRC_REG);

  assert_pin_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_src == SRC_PIN && $past(ctrl_src) == SRC_NONE) |-> $past(wait_expired));

  assert_reg_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_src == SRC_REG && $past(ctrl_src) != SRC_REG) |-> $past(cpen_write));

  assert_ready_after_pwrup_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(filt_ready) |-> $past(pwr_state) == PS_PWRUP);

  assert_hold_only_reg_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_state == PS_HOLD |-> ctrl_src == SRC_REG);

  assert_mute_not_running_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_state != PS_RUN |-> mute_out == '1);

  assert_ramp_reg_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_src != SRC_REG |-> (!ramp_up_en && !ramp_dn_en));

  assert_pin_mode_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_src == SRC_PIN && $past(ctrl_src) == SRC_PIN) |-> $stable(active_mode));
endmodule

bind dac_pwr_seq dac_pwr_seq_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_src(ctrl_src), .pwr_state(pwr_state),
  .filt_ready(filt_ready), .ramp_up_en(ramp_up_en), .ramp_dn_en(ramp_dn_en),
  .mute_out(mute_out), .active_mode(active_mode), .wait_expired(wait_expired),
  .cpen_write(cpen_write)
);

// File: tb/test_dac_pwr_seq.sv
module test_dac_pwr_seq;
  localparam int NCH = 8;
  localparam int PW  = 40;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           frame_clk = 1'b0;
  logic [1:0]     speed_sel = 2'd0;
  logic [3:0]     mode_pins = 4'd0;
  logic           wr_en = 1'b0;
  logic [1:0]     wr_sel = 2'd0;
  logic [NCH-1:0] wr_data = '0;
  logic [1:0]     ctrl_src, pwr_state;
  logic           filt_ready, ramp_up_en, ramp_dn_en;
  logic [NCH-1:0] mute_out;
  logic [3:0]     active_mode;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  dac_pwr_seq #(.NCH(NCH), .BASE_FRAMES(512), .PWRUP_CYCLES(PW)) i_dac_pwr_seq (
    .clk(clk), .rst_n(rst_n), .frame_clk(frame_clk), .speed_sel(speed_sel),
    .mode_pins(mode_pins), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .ctrl_src(ctrl_src), .pwr_state(pwr_state), .filt_ready(filt_ready),
    .ramp_up_en(ramp_up_en), .ramp_dn_en(ramp_dn_en), .mute_out(mute_out),
    .active_mode(active_mode)
  );

  // speed, pins, expected frame count
  localparam logic [17:0] VEC [4] = '{
    {2'd0, 4'h5, 12'd512},
    {2'd1, 4'hA, 12'd1024},
    {2'd2, 4'h3, 12'd2048},
    {2'd3, 4'hC, 12'd512}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] spd, input logic [3:0] pins);
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0; frame_clk = 1'b0;
    speed_sel = spd; mode_pins = pins;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic frames(input int n);
    for (int i = 0; i < n; i++) begin
      frame_clk = 1'b1;
      repeat (4) @(negedge clk);
      frame_clk = 1'b0;
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [NCH-1:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1 reset state
    do_reset(2'd0, 4'h0);
    chk("R1 src", ctrl_src, 0);
    chk("R1 state", pwr_state, 0);
    chk("R1 filt", filt_ready, 0);
    chk("R1 mute", mute_out, 8'hFF);
    chk("R1 ramp", {ramp_up_en, ramp_dn_en}, 0);
    chk("R1 mode", active_mode, 0);

    // Table walk: wait length per speed, pin sequence
    for (int v = 0; v < 4; v++) begin
      do_reset(VEC[v][17:16], VEC[v][15:12]);
      frames(int'(VEC[v][11:0]) - 1);
      repeat (2) @(negedge clk);
      chk("R2 still waiting", ctrl_src, 0);
      frames(1);
      chk("R4 pin source", ctrl_src, 1);
      chk("R4 pin mode", active_mode, VEC[v][15:12]);
      chk("R4 powering", pwr_state, 2);
      repeat (PW + 10) @(negedge clk);
      chk("R4 running", pwr_state, 3);
      chk("R7 pin mute", mute_out, 0);
      chk("R8 pin ramp", {ramp_up_en, ramp_dn_en}, 0);
      mode_pins = ~VEC[v][15:12];
      repeat (5) @(negedge clk);
      chk("R9 pins ignored", active_mode, VEC[v][15:12]);
    end

    // R5 late takeover from pin control
    wr(2'd0, 8'b0000_0001);
    chk("R5 takeover src", ctrl_src, 2);
    chk("R5 restart pwrup", pwr_state, 2);
    frames(3);
    chk("R5 src sticky", ctrl_src, 2);
    repeat (PW + 10) @(negedge clk);
    chk("R5 running", pwr_state, 3);

    // R3/R6/R7/R8/R9/R10 early enable, register control
    do_reset(2'd0, 4'h6);
    frames(10);
    wr(2'd0, 8'b0000_0011);
    chk("R3 reg src", ctrl_src, 2);
    chk("R6 parked", pwr_state, 1);
    frames(600);
    chk("R3 no pin seq", ctrl_src, 2);
    chk("R6 still parked", pwr_state, 1);
    chk("R6 filt low", filt_ready, 0);
    wr(2'd1, 8'hA5);
    wr(2'd2, 8'h09);
    chk("R9 reg mode", active_mode, 4'h9);
    wr(2'd0, 8'b0000_1101);
    chk("R8 ramp bits", {ramp_up_en, ramp_dn_en}, 2'b11);
    chk("R7 mute while pwrup", mute_out, 8'hFF);
    repeat (PW - 5) @(negedge clk);
    chk("R6 not yet", pwr_state, 2);
    repeat (10) @(negedge clk);
    chk("R6 running", pwr_state, 3);
    chk("R6 filt ready", filt_ready, 1);
    chk("R7 reg mute", mute_out, 8'hA5);
    wr(2'd0, 8'b0000_0011);
    chk("R10 parked", pwr_state, 1);
    chk("R10 filt low", filt_ready, 0);
    chk("R10 mute", mute_out, 8'hFF);
    chk("R8 ramp cleared", {ramp_up_en, ramp_dn_en}, 2'b00);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule